// File: doc/BRIEF.md
# Tuning-aware interrupt status unit

This block holds the interrupt status word, its status-enable word and its signal-enable word for an SD/MMC host controller that runs a sampling-clock tuning sequence. Event sources inside the controller raise one-cycle pulses: data CRC error, block read ready, command complete and so on. Each event bit is latched into the status word only if its status-enable bit is set and the tuning rules allow it. Software clears status bits by writing ones to them. A single registered interrupt line reports whether any latched status bit also has its signal-enable bit set.

During tuning, the controller reads tuning blocks again and again while it steps a delay ratio. Any read may fail its CRC. The CRC verdict for the final block can arrive after the live tuning flag has already dropped. Because of this, every event carries a sideband tag. The tag is captured when the block that produced the event started, and it records whether tuning was then active. An event is dropped if either the live tuning flag or its own tag is set. Block read ready is the one exception: it passes in both cases.

Top module: `sd_irq_status`

## Requirements
- R1: After reset, the status word, both enable words and the interrupt line are all zero.
- R2: Suppose an event bit pulses while its status-enable bit is 1, its tag bit is 0 and the tuning flag is 0. Then the matching status bit reads 1 after the next clock edge and stays 1 until it is cleared.
- R3: While the tuning flag is 1, no status bit other than block read ready (bit 5) can go from 0 to 1, whatever the event and tag inputs are.
- R4: Suppose an event arrives with its tag bit set, for example a data CRC error (bit 21) from the last tuning block arriving after the tuning flag has fallen. That event sets no status bit.
- R5: Block read ready (bit 5) is latched during tuning and with its tag set, but only when its status-enable bit is 1.
- R6: A status bit whose status-enable bit is 0 is never set by its event. This includes data CRC error at bit 21.
- R7: A write to the status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R8: When a clearing write and a passing event hit the same bit in the same cycle, the bit ends up 1.
- R9: The interrupt line equals, one cycle later, the OR over all bits of status AND signal-enable.
- R10: A write to either enable word loads the write data on that clock edge. The new value first gates events in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tune_i | input | 1 | Live tuning-active flag |
| ev_i | input | W | One-cycle event pulses, one bit per status source |
| ev_tag_i | input | W | Per-event flag: tuning was active when the event's block started |
| wr_stat_i | input | 1 | Write-1-to-clear strobe for the status word |
| wr_sten_i | input | 1 | Load strobe for the status-enable word |
| wr_sigen_i | input | 1 | Load strobe for the signal-enable word |
| wdata_i | input | W | Write data shared by the three strobes |
| stat_o | output | W | Latched status word |
| sten_o | output | W | Status-enable word |
| sigen_o | output | W | Signal-enable word |
| irq_o | output | 1 | Registered interrupt line |

## Verification
If a tuning qualifier is applied wrongly, a stray status bit shows on stat_o one edge after the offending event. The interrupt line then shows the same fault one edge later. The most important case is a late data CRC error carrying the tuning tag: it must leave bit 21 at zero, and the same error without the tag must set it. A broken clear path or a broken enable path shows on the very next read of the ports. This is why every cycle of the mixed random and directed run compares all four outputs against an independent model.

// File: rtl/sd_irq_status.sv
module sd_irq_status #(
  parameter int W        = 32,
  parameter int BRR_BIT  = 5,
  parameter int DCRC_BIT = 21
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tune_i,
  input  logic [W-1:0] ev_i,
  input  logic [W-1:0] ev_tag_i,
  input  logic         wr_stat_i,
  input  logic         wr_sten_i,
  input  logic         wr_sigen_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] sten_o,
  output logic [W-1:0] sigen_o,
  output logic         irq_o
);
  localparam logic [W-1:0] BRR_ONLY = {{(W-1){1'b0}}, 1'b1} << BRR_BIT;

  logic [W-1:0] stat_q, sten_q, sigen_q;
  logic         irq_q;

  wire [W-1:0] allow = tune_i ? BRR_ONLY : (~ev_tag_i | BRR_ONLY);
  wire [W-1:0] set_v = ev_i & sten_q & allow;
  wire [W-1:0] clr_v = wr_stat_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      sten_q  <= '0;
      sigen_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;
      if (wr_sten_i)  sten_q  <= wdata_i;
      if (wr_sigen_i) sigen_q <= wdata_i;
      irq_q <= |(stat_q & sigen_q);
    end
  end

  assign stat_o  = stat_q;
  assign sten_o  = sten_q;
  assign sigen_o = sigen_q;
  assign irq_o   = irq_q;

  p_tune_mask_r3: assert property (@(posedge clk) disable iff (rst)
    tune_i |=> ((stat_q & ~$past(stat_q) & ~BRR_ONLY) == '0));

  p_late_crc_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_tag_i[DCRC_BIT] && !stat_q[DCRC_BIT]) |=> !stat_q[DCRC_BIT]);

  p_en_gate_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(sten_q)) == '0));

  p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_stat_i && ev_i == '0) |=> ((stat_q & $past(wdata_i)) == '0));

  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_q == |($past(stat_q) & $past(sigen_q))));
endmodule

// File: tb/sd_irq_status_test.sv
module sd_irq_status_test;
  localparam int W = 32;
  localparam int BRR = 5;
  localparam int DCRC = 21;
  localparam logic [W-1:0] BRRM = 32'h1 << BRR;
  localparam logic [W-1:0] DCRCM = 32'h1 << DCRC;

  logic clk = 0, rst = 1, tune = 0, ws = 0, we = 0, wg = 0;
  logic [W-1:0] ev = '0, tag = '0, wd = '0;
  logic [W-1:0] stat, sten, sigen;
  logic irq;
  logic [W-1:0] es = '0, ee = '0, eg = '0;
  logic ei = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sd_irq_status #(.W(W), .BRR_BIT(BRR), .DCRC_BIT(DCRC)) uut (
    .clk(clk), .rst(rst), .tune_i(tune), .ev_i(ev), .ev_tag_i(tag),
    .wr_stat_i(ws), .wr_sten_i(we), .wr_sigen_i(wg), .wdata_i(wd),
    .stat_o(stat), .sten_o(sten), .sigen_o(sigen), .irq_o(irq));

  function automatic logic [W-1:0] pass_mask(logic tn, logic [W-1:0] tg);
    return tn ? BRRM : (~tg | BRRM);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(stat == es, {req, " stat"}, stat, es);
    chk(sten == ee, {req, " sten"}, sten, ee);
    chk(sigen == eg, {req, " sigen"}, sigen, eg);
    chk(irq == ei, {req, " irq R9"}, {31'd0, irq}, {31'd0, ei});
  endtask

  task automatic step(input logic [W-1:0] e, input logic [W-1:0] t, input logic tn,
                      input logic s, input logic en, input logic g,
                      input logic [W-1:0] d, input string req);
    ev = e; tag = t; tune = tn; ws = s; we = en; wg = g; wd = d;
    ei = |(es & eg);
    es = (es & ~(s ? d : '0)) | (e & ee & pass_mask(tn, t));
    if (en) ee = d;
    if (g) eg = d;
    @(posedge clk);
    @(negedge clk);
    ev = '0; tag = '0; ws = 0; we = 0; wg = 0;
    compare(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 0;
    compare("R1 reset");

    step('0, '0, 0, 0, 1, 0, '1, "R10 sten load");
    step('0, '0, 0, 0, 0, 1, '1, "R10 sigen load");

    step(DCRCM, DCRCM, 0, 0, 0, 0, '0, "R4 late crc");
    chk(stat[DCRC] == 1'b0, "R4 bit21 masked", stat, '0);
    step(DCRCM, '0, 0, 0, 0, 0, '0, "R2 crc outside tuning");
    chk(stat[DCRC] == 1'b1, "R2 bit21 set", stat, DCRCM);
    step('0, '0, 0, 0, 0, 0, '0, "R9 irq follows");
    chk(irq == 1'b1, "R9 irq high", {31'd0, irq}, 32'd1);

    step('0, '0, 0, 1, 0, 0, ~DCRCM, "R7 write zero keeps");
    chk(stat[DCRC] == 1'b1, "R7 bit21 kept", stat, DCRCM);
    step('0, '0, 0, 1, 0, 0, DCRCM, "R7 write one clears");
    chk(stat == '0, "R7 cleared", stat, '0);

    step('1, '0, 1, 0, 0, 0, '0, "R3 tuning masks");
    chk(stat == BRRM, "R3 R5 only brr", stat, BRRM);
    step('0, '0, 0, 1, 0, 0, '1, "R7 clear all");
    step('0, '0, 0, 0, 1, 0, ~(BRRM | DCRCM), "R10 sten partial");
    step(BRRM | DCRCM, '0, 1, 0, 0, 0, '0, "R5 brr needs enable");
    chk(stat == '0, "R5 brr disabled", stat, '0);
    step(DCRCM, '0, 0, 0, 0, 0, '0, "R6 crc disabled");
    chk(stat[DCRC] == 1'b0, "R6 bit21 not set", stat, '0);

    step('0, '0, 0, 0, 1, 0, '1, "R10 sten full");
    step(DCRCM, '0, 0, 0, 0, 0, '0, "R2 set again");
    step(DCRCM, '0, 0, 1, 0, 0, DCRCM, "R8 clear and set");
    chk(stat[DCRC] == 1'b1, "R8 set wins", stat, DCRCM);

    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] re, rt, rd;
      logic rtn, rs, ren, rg;
      re  = $urandom & $urandom & $urandom;
      rt  = $urandom;
      rtn = ($urandom % 4) == 0;
      rs  = ($urandom % 5) == 0;
      ren = ($urandom % 40) == 0;
      rg  = ($urandom % 40) == 0;
      rd  = $urandom;
      step(re, rt, rtn, rs, ren, rg, rd, "R2 R3 R4 R6 R7 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule